// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit computes the basic bit-manipulation operations of a 32-bit integer datapath. A 5-bit operation code selects one result from two source operands and an immediate rotate amount. The operations are inverted-operand logic, bit counting, signed and unsigned minimum and maximum, sign and zero extension, rotation, byte-wise OR-combine and byte-order reversal. The result is a single 32-bit word. The surrounding pipeline handles decoding and operand fetch, and it writes the result back.

A parameter selects where the result comes out. With `OUT_REG = 1`, the result and a valid flag are registered and appear one clock after the inputs. The register loads only on valid cycles. With `OUT_REG = 0`, the result is purely combinational and the valid flag passes straight through.

Top module: `bitmanip_alu`

## Requirements
- R1: Code 0 gives src_a AND NOT src_b, code 1 gives src_a OR NOT src_b, and code 2 gives NOT (src_a XOR src_b).
- R2: Code 3 returns the count of zero bits above the highest set bit of src_a. Code 4 returns the count of zero bits below the lowest set bit. When src_a is zero, both return 32.
- R3: Code 5 returns the number of set bits in src_a. Every count result is zero-extended, so bits 31:6 of a count are zero.
- R4: Codes 6 (maximum) and 8 (minimum) compare the operands as signed two's-complement numbers. Codes 7 (maximum) and 9 (minimum) compare them as unsigned numbers.
- R5: Code 10 fills bits 31:8 with bit 7 of src_a. Code 11 fills bits 31:16 with bit 15. Code 12 keeps bits 15:0 and clears bits 31:16.
- R6: Code 13 rotates src_a left and code 14 rotates it right, both by src_b[4:0]. Bits 31:5 of src_b have no effect, and an amount of zero returns src_a unchanged.
- R7: Code 15 rotates src_a right by imm_amt. src_b has no effect on this operation.
- R8: For code 16, each result byte is 0xFF if any bit of the matching src_a byte is set, and 0x00 otherwise.
- R9: Code 17 reverses byte order: result byte k equals src_a byte 3-k.
- R10: Codes 18 through 31 produce a zero result.
- R11: With OUT_REG=1, result and out_valid appear at the clock edge after the inputs, and out_valid equals the in_valid that was sampled at that edge. Reset clears both to zero.
- R12: With OUT_REG=1, a cycle with in_valid low leaves result unchanged, whatever the operands and code are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| op_sel | input | 5 | Operation code |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand or rotate amount |
| imm_amt | input | 5 | Immediate rotate amount |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Operation result |

## Verification
The bench builds the unit with XLEN=32 and OUT_REG=1. In this configuration, every operation has a fixed one-cycle latency, which lets the checks observe the reset value, the valid flag and the hold behaviour of the output register. All eighteen codes and the unused code range are exercised. Each operation is driven with the operand corners zero, all-ones, 0x80000000 and 0x00000001, with rotate amounts whose upper bits are set, and with random operands compared against a loop-based reference model.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ANDN  = 5'd0,
    OP_ORN   = 5'd1,
    OP_XNOR  = 5'd2,
    OP_CLZ   = 5'd3,
    OP_CTZ   = 5'd4,
    OP_CPOP  = 5'd5,
    OP_MAX   = 5'd6,
    OP_MAXU  = 5'd7,
    OP_MIN   = 5'd8,
    OP_MINU  = 5'd9,
    OP_SEXTB = 5'd10,
    OP_SEXTH = 5'd11,
    OP_ZEXTH = 5'd12,
    OP_ROL   = 5'd13,
    OP_ROR   = 5'd14,
    OP_RORI  = 5'd15,
    OP_ORCB  = 5'd16,
    OP_REV8  = 5'd17
  } bmu_op_e;

  localparam int LAST_OP = 17;

  function automatic logic is_count(input logic [OP_W-1:0] op);
    return (op == OP_CLZ) || (op == OP_CTZ) || (op == OP_CPOP);
  endfunction
endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int XLEN = 32,
  localparam int CW = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] a,
  output logic [CW-1:0]   lead_zeros,
  output logic [CW-1:0]   trail_zeros,
  output logic [CW-1:0]   ones
);
  // Highest set bit wins for leading zeros; scan upward so the last hit stays.
  always_comb begin
    lead_zeros = CW'(XLEN);
    for (int i = 0; i < XLEN; i++)
      if (a[i]) lead_zeros = CW'(XLEN - 1 - i);
  end

  // Lowest set bit wins for trailing zeros; scan downward.
  always_comb begin
    trail_zeros = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--)
      if (a[i]) trail_zeros = CW'(i);
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < XLEN; i++)
      ones = ones + CW'(a[i]);
  end
endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
  parameter int XLEN = 32,
  localparam int SW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a,
  input  logic [SW-1:0]   amt,
  input  logic            to_left,
  output logic [XLEN-1:0] y
);
  logic [2*XLEN-1:0] doubled;
  logic [XLEN-1:0]   rot_r;
  logic [XLEN-1:0]   rot_l;

  assign doubled = {a, a};
  assign rot_r   = XLEN'(doubled >> amt);
  assign rot_l   = XLEN'((doubled << amt) >> XLEN);
  assign y       = to_left ? rot_l : rot_r;
endmodule

// File: rtl/bmu_bytes.sv
module bmu_bytes #(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8
) (
  input  logic [XLEN-1:0] a,
  output logic [XLEN-1:0] or_comb,
  output logic [XLEN-1:0] reversed
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign or_comb[8*k +: 8]         = {8{|a[8*k +: 8]}};
    assign reversed[8*(NB-1-k) +: 8] = a[8*k +: 8];
  end
endmodule

// File: rtl/bitmanip_alu.sv
module bitmanip_alu
  import bmu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int SW = $clog2(XLEN),
  localparam int CW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op_sel,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [SW-1:0]   imm_amt,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);
  // Named internal wires, visible to the bound checker.
  logic [CW-1:0]   lead_zeros, trail_zeros, ones;
  logic [SW-1:0]   rot_amt;
  logic            rot_left;
  logic [XLEN-1:0] rot_res, orc_res, rev_res;
  logic            a_lt_b_s, a_lt_b_u;
  logic [XLEN-1:0] comb_res;

  bmu_count #(.XLEN(XLEN)) u_count (
    .a(src_a), .lead_zeros(lead_zeros), .trail_zeros(trail_zeros), .ones(ones)
  );

  assign rot_amt  = (op_sel == OP_RORI) ? imm_amt : src_b[SW-1:0];
  assign rot_left = (op_sel == OP_ROL);

  bmu_rotate #(.XLEN(XLEN)) u_rotate (
    .a(src_a), .amt(rot_amt), .to_left(rot_left), .y(rot_res)
  );

  bmu_bytes #(.XLEN(XLEN)) u_bytes (
    .a(src_a), .or_comb(orc_res), .reversed(rev_res)
  );

  assign a_lt_b_s = $signed(src_a) < $signed(src_b);
  assign a_lt_b_u = src_a < src_b;

  always_comb begin
    case (bmu_op_e'(op_sel))
      OP_ANDN:  comb_res = src_a & ~src_b;
      OP_ORN:   comb_res = src_a | ~src_b;
      OP_XNOR:  comb_res = ~(src_a ^ src_b);
      OP_CLZ:   comb_res = XLEN'(lead_zeros);
      OP_CTZ:   comb_res = XLEN'(trail_zeros);
      OP_CPOP:  comb_res = XLEN'(ones);
      OP_MAX:   comb_res = a_lt_b_s ? src_b : src_a;
      OP_MAXU:  comb_res = a_lt_b_u ? src_b : src_a;
      OP_MIN:   comb_res = a_lt_b_s ? src_a : src_b;
      OP_MINU:  comb_res = a_lt_b_u ? src_a : src_b;
      OP_SEXTB: comb_res = {{(XLEN-8){src_a[7]}}, src_a[7:0]};
      OP_SEXTH: comb_res = {{(XLEN-16){src_a[15]}}, src_a[15:0]};
      OP_ZEXTH: comb_res = {{(XLEN-16){1'b0}}, src_a[15:0]};
      OP_ROL, OP_ROR, OP_RORI: comb_res = rot_res;
      OP_ORCB:  comb_res = orc_res;
      OP_REV8:  comb_res = rev_res;
      default:  comb_res = '0;
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) result <= comb_res;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = comb_res;
  end
endmodule

// File: rtl/bitmanip_alu_chk.sv
module bitmanip_alu_chk
  import bmu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int SW = $clog2(XLEN),
  localparam int CW = $clog2(XLEN + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OP_W-1:0] op_sel,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [SW-1:0]   imm_amt,
  input logic [XLEN-1:0] comb_res,
  input logic            out_valid,
  input logic [XLEN-1:0] result
);
  // R3
  count_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_count(op_sel)) |-> (comb_res[XLEN-1:CW] == '0));

  // R2
  zero_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_CLZ && src_a == '0) |-> (comb_res == XLEN'(XLEN)));

  // R10
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel > 5'(LAST_OP)) |-> (comb_res == '0));

  // R6
  rot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == OP_ROL || op_sel == OP_ROR) && src_b[SW-1:0] == '0)
      |-> (comb_res == src_a));

  // R7
  rori_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_RORI && imm_amt == '0) |-> (comb_res == src_a));

  // R4
  maxu_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_MAXU) |-> (comb_res >= src_a && comb_res >= src_b));

  // R4
  minu_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_MINU) |-> (comb_res <= src_a && comb_res <= src_b));

  // R8
  for (genvar k = 0; k < XLEN / 8; k++) begin : g_orc
    orcb_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_ORCB)
        |-> (comb_res[8*k +: 8] == 8'h00 || comb_res[8*k +: 8] == 8'hFF));
  end

  if (OUT_REG) begin : g_reg_chk
    // R11
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid));
    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid) |=> $stable(result));
  end
endmodule

bind bitmanip_alu bitmanip_alu_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .src_a(src_a), .src_b(src_b), .imm_amt(imm_amt), .comb_res(comb_res),
  .out_valid(out_valid), .result(result)
);

// File: tb/test_bitmanip_alu.sv
module test_bitmanip_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [4:0]  imm_amt = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bitmanip_alu #(.XLEN(32), .OUT_REG(1'b1)) i_bitmanip_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .imm_amt(imm_amt),
    .out_valid(out_valid), .result(result)
  );

  logic [31:0] corners [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001};

  // Reference model written independently: bitwise loops and single-step rotates.
  function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] imm);
    logic [31:0] r;
    int n;
    r = '0;
    case (op)
      5'd0: for (int i = 0; i < 32; i++) r[i] = a[i] & !b[i];
      5'd1: for (int i = 0; i < 32; i++) r[i] = a[i] | !b[i];
      5'd2: for (int i = 0; i < 32; i++) r[i] = (a[i] == b[i]);
      5'd3: begin n = 0; while (n < 32 && !a[31-n]) n++; r = 32'(n); end
      5'd4: begin n = 0; while (n < 32 && !a[n]) n++; r = 32'(n); end
      5'd5: begin n = 0; for (int i = 0; i < 32; i++) if (a[i]) n++; r = 32'(n); end
      5'd6: r = ((a ^ 32'h8000_0000) > (b ^ 32'h8000_0000)) ? a : b;
      5'd7: r = (a > b) ? a : b;
      5'd8: r = ((a ^ 32'h8000_0000) < (b ^ 32'h8000_0000)) ? a : b;
      5'd9: r = (a < b) ? a : b;
      5'd10: r = a[7] ? (a | 32'hFFFF_FF00) : (a & 32'h0000_00FF);
      5'd11: r = a[15] ? (a | 32'hFFFF_0000) : (a & 32'h0000_FFFF);
      5'd12: r = a & 32'h0000_FFFF;
      5'd13: begin r = a; for (int i = 0; i < int'(b[4:0]); i++) r = {r[30:0], r[31]}; end
      5'd14: begin r = a; for (int i = 0; i < int'(b[4:0]); i++) r = {r[0], r[31:1]}; end
      5'd15: begin r = a; for (int i = 0; i < int'(imm); i++) r = {r[0], r[31:1]}; end
      5'd16: for (int k = 0; k < 4; k++) if (a[8*k +: 8] != 0) r[8*k +: 8] = 8'hFF;
      5'd17: for (int k = 0; k < 4; k++) r[8*k +: 8] = a[8*(3-k) +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one valid operation, sample after the output register has loaded.
  task automatic run_op(input string req, input logic [4:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] imm);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; imm_amt = imm;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, result, model(op, a, b, imm));
  endtask

  task automatic test_reset();
    check("R11 reset result", result, 32'h0);
    check("R11 reset valid", {31'b0, out_valid}, 32'h0);
  endtask

  task automatic test_logic();
    foreach (corners[i]) foreach (corners[j]) begin
      run_op("R1 andn", 5'd0, corners[i], corners[j], 5'd0);
      run_op("R1 orn",  5'd1, corners[i], corners[j], 5'd0);
      run_op("R1 xnor", 5'd2, corners[i], corners[j], 5'd0);
    end
    run_op("R1 andn", 5'd0, 32'hF0F0_1234, 32'h0FF0_0204, 5'd0);
    check("R1 andn value", result, 32'hF000_1030);
  endtask

  task automatic test_counts();
    run_op("R2 clz zero", 5'd3, 32'h0, 32'h0, 5'd0);
    check("R2 clz zero is 32", result, 32'd32);
    run_op("R2 ctz zero", 5'd4, 32'h0, 32'h0, 5'd0);
    check("R2 ctz zero is 32", result, 32'd32);
    run_op("R2 clz msb", 5'd3, 32'h8000_0000, 32'h0, 5'd0);
    check("R2 clz msb is 0", result, 32'd0);
    run_op("R2 ctz msb", 5'd4, 32'h8000_0000, 32'h0, 5'd0);
    check("R2 ctz msb is 31", result, 32'd31);
    run_op("R2 clz one", 5'd3, 32'h1, 32'h0, 5'd0);
    check("R2 clz one is 31", result, 32'd31);
    run_op("R3 cpop ones", 5'd5, 32'hFFFF_FFFF, 32'h0, 5'd0);
    check("R3 cpop ones is 32", result, 32'd32);
    foreach (corners[i]) run_op("R3 cpop", 5'd5, corners[i], 32'h0, 5'd0);
  endtask

  task automatic test_minmax();
    run_op("R4 max signed", 5'd6, 32'h8000_0000, 32'h1, 5'd0);
    check("R4 max picks 1", result, 32'h1);
    run_op("R4 maxu", 5'd7, 32'h8000_0000, 32'h1, 5'd0);
    check("R4 maxu picks msb", result, 32'h8000_0000);
    run_op("R4 min signed", 5'd8, 32'hFFFF_FFFF, 32'h0, 5'd0);
    check("R4 min picks -1", result, 32'hFFFF_FFFF);
    run_op("R4 minu", 5'd9, 32'hFFFF_FFFF, 32'h0, 5'd0);
    check("R4 minu picks 0", result, 32'h0);
    foreach (corners[i]) foreach (corners[j])
      for (int op = 6; op <= 9; op++)
        run_op("R4 minmax", 5'(op), corners[i], corners[j], 5'd0);
  endtask

  task automatic test_ext();
    run_op("R5 sextb", 5'd10, 32'h1234_5680, 32'h0, 5'd0);
    check("R5 sextb neg", result, 32'hFFFF_FF80);
    run_op("R5 sexth", 5'd11, 32'hABCD_7FFF, 32'h0, 5'd0);
    check("R5 sexth pos", result, 32'h0000_7FFF);
    run_op("R5 zexth", 5'd12, 32'hFFFF_8001, 32'h0, 5'd0);
    check("R5 zexth", result, 32'h0000_8001);
    foreach (corners[i])
      for (int op = 10; op <= 12; op++) run_op("R5 ext", 5'(op), corners[i], 32'h0, 5'd0);
  endtask

  task automatic test_rotate();
    run_op("R6 rol", 5'd13, 32'h8000_0001, 32'hFFFF_FFE1, 5'd0);
    check("R6 rol high bits ignored", result, 32'h0000_0003);
    run_op("R6 ror", 5'd14, 32'h0000_0001, 32'h0000_0104, 5'd0);
    check("R6 ror high bits ignored", result, 32'h1000_0000);
    run_op("R6 rol zero", 5'd13, 32'hDEAD_BEEF, 32'hFFFF_FFE0, 5'd0);
    check("R6 rol zero amount", result, 32'hDEAD_BEEF);
    run_op("R7 rori", 5'd15, 32'h0000_00FF, 32'h0000_0003, 5'd8);
    check("R7 rori imm", result, 32'hFF00_0000);
    run_op("R7 rori zero", 5'd15, 32'h1234_5678, 32'h0000_0010, 5'd0);
    check("R7 rori zero amount", result, 32'h1234_5678);
    for (int s = 0; s < 32; s += 7) begin
      run_op("R6 rol sweep", 5'd13, 32'h8000_0001, 32'(s), 5'd0);
      run_op("R6 ror sweep", 5'd14, 32'h8000_0001, 32'(s), 5'd0);
      run_op("R7 rori sweep", 5'd15, 32'h8000_0001, 32'h0, 5'(s));
    end
  endtask

  task automatic test_bytes();
    run_op("R8 orcb", 5'd16, 32'h0080_0100, 32'h0, 5'd0);
    check("R8 orcb value", result, 32'h00FF_FF00);
    run_op("R9 rev8", 5'd17, 32'h1122_3344, 32'h0, 5'd0);
    check("R9 rev8 value", result, 32'h4433_2211);
    foreach (corners[i]) begin
      run_op("R8 orcb corner", 5'd16, corners[i], 32'h0, 5'd0);
      run_op("R9 rev8 corner", 5'd17, corners[i], 32'h0, 5'd0);
    end
  endtask

  task automatic test_unused();
    for (int op = 18; op < 32; op++) begin
      run_op("R10 unused code", 5'(op), 32'hFFFF_FFFF, 32'h1234_5678, 5'd31);
      check("R10 unused zero", result, 32'h0);
    end
  endtask

  task automatic test_valid();
    @(negedge clk);
    in_valid = 1'b1; op_sel = 5'd17; src_a = 32'hA1B2_C3D4; src_b = '0; imm_amt = '0;
    @(negedge clk);
    check("R11 valid after one edge", {31'b0, out_valid}, 32'h1);
    check("R11 result after one edge", result, 32'hD4C3_B2A1);
    in_valid = 1'b0; op_sel = 5'd1; src_a = 32'h0; src_b = 32'h0;
    @(negedge clk);
    check("R11 valid drops", {31'b0, out_valid}, 32'h0);
    check("R12 result held", result, 32'hD4C3_B2A1);
    op_sel = 5'd5; src_a = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R12 result still held", result, 32'hD4C3_B2A1);
  endtask

  task automatic test_random();
    for (int n = 0; n < 400; n++) begin
      logic [4:0] op;
      logic [31:0] a, b;
      op = 5'($urandom_range(0, 19));
      a  = $urandom;
      b  = $urandom;
      run_op($sformatf("R%0d random op %0d", 0, op), op, a, b, 5'($urandom));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_logic();
    test_counts();
    test_minmax();
    test_ext();
    test_rotate();
    test_bytes();
    test_unused();
    test_valid();
    test_random();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule